// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment-relative memory reference into a flat physical address. It holds four segment base registers: code, data, stack and extra. For each accepted request it picks one of them from the kind of access being made, shifts that base left by four bits and adds the 16-bit offset. The result is a 20-bit address in a 1-Mbyte space, and each segment covers 64K contiguous bytes. A segment-override input can redirect ordinary data and stack references to any of the four registers. Instruction fetches and string destinations always keep their fixed register.

The same request port also forms I/O port addresses. A narrow 8-bit port number is zero-extended to 16 bits. A full 16-bit port value taken from a register passes through unchanged. A synchronous write port loads the segment registers. A request issued in the same cycle as a write to the register it uses sees the new value. Results come out registered, one cycle after the request, together with a valid strobe and a memory/I/O flag.

Top module: `seg_addr_gen`

## Requirements
- R1: For a memory request, the output address equals (segment << 4) + offset. It appears with `addr_valid` high on the cycle after `req_valid` was sampled high, and `addr_is_io` is low.
- R2: After a synchronous active-low reset, `addr_valid` is low, the code segment holds 16'hFFFF and the data, stack and extra segments hold 16'h0000.
- R3: Access class 0 (instruction fetch) always uses the code segment, even when `ovr_valid` is high.
- R4: Access class 1 (general data) uses the data segment when `ovr_valid` is low.
- R5: Access class 2 (stack push/pop or BP-based reference) uses the stack segment when `ovr_valid` is low.
- R6: Access class 3 (string destination indexed by DI) always uses the extra segment, even when `ovr_valid` is high.
- R7: For classes 1 and 2 with `ovr_valid` high, `ovr_seg` picks the segment: 0 = code, 1 = data, 2 = stack, 3 = extra.
- R8: When `wr_en` is high, segment register `wr_idx` (same encoding as R7) takes `wr_data` at the clock edge. A request in that same cycle that uses that register sees `wr_data`.
- R9: For an I/O request with `io_wide` low, the port address is offset[7:0] zero-extended. Output bits 19..8 are zero and `addr_is_io` is high.
- R10: For an I/O request with `io_wide` high, the full 16-bit offset is the port address, with output bits 19..16 zero and `addr_is_io` high.
- R11: A carry out of bit 19 of the add is dropped, so addresses wrap modulo 2^20. For example, segment FFFF with offset FFFF gives 0FFEF.
- R12: On the cycle after `req_valid` was sampled low, `addr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Segment register write enable |
| wr_idx | input | 2 | Segment register to write (0 code, 1 data, 2 stack, 3 extra) |
| wr_data | input | 16 | Value written to the segment register |
| req_valid | input | 1 | Request strobe |
| req_io | input | 1 | 1 = I/O port address, 0 = memory address |
| io_wide | input | 1 | I/O only: 1 = 16-bit register port, 0 = 8-bit immediate port |
| acc_class | input | 2 | 0 fetch, 1 data, 2 stack/BP, 3 string destination |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment choice |
| offset | input | 16 | Memory offset or I/O port value |
| addr_valid | output | 1 | Registered address is valid |
| addr_is_io | output | 1 | Registered address is an I/O port |
| addr | output | 20 | Registered physical or port address |

## Verification
The bench uses the default parameters: 16-bit segments and offsets, a 4-bit shift, a 20-bit physical address and an 8-bit narrow port width. With these values a segment of FFFF and a large offset reach the carry out of bit 19, so the wrap case is exercised directly. Random narrow-port values with high offset bits set show that those bits are dropped. Back-to-back writes and requests to the same register, all four override codes and both fixed-segment classes are covered, and a bench model of the four registers supplies the expected value for every random request.

// File: rtl/seg_addr_pkg.sv
// Shared encodings for the segmented address generator.
// Assumes exactly four segment registers indexed with two bits.
package seg_addr_pkg;

    localparam int NUM_SEG = 4;
    localparam int IDX_W   = 2;

    // Segment register index; the numbering is visible at the write and override ports.
    typedef enum logic [IDX_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_idx_e;

    // Kind of memory reference, which decides the implied segment.
    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_DATA   = 2'd1,
        ACC_STACK  = 2'd2,
        ACC_STRDST = 2'd3
    } acc_class_e;

endpackage

// File: rtl/seg_regfile.sv
// Segment register file: NUM_SEG registers of SEG_W bits, one synchronous
// write port and one combinational read port with write-to-read bypass.
// Assumes synchronous active-low reset; register 0 resets to CODE_RST.
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int                SEG_W    = 16,
    parameter logic [SEG_W-1:0]  CODE_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SEG_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [SEG_W-1:0]  rd_data
);

    logic [SEG_W-1:0] regs [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_reg
        localparam logic [SEG_W-1:0] RST_VAL = (g == int'(SEG_CODE)) ? CODE_RST : '0;
        // Hold one segment base, loading it when addressed by the write port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= RST_VAL;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                regs[g] <= wr_data;
        end
    end

    // Read the selected register, forwarding a same-cycle write to it.
    always_comb begin
        if (wr_en && (wr_idx == rd_idx))
            rd_data = wr_data;
        else
            rd_data = regs[rd_idx];
    end

    // R8
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/seg_select.sv
// Segment choice: maps the access class to its implied segment and applies
// an override only to classes that allow it (data and stack).
// Assumes acc_class is meaningful only for memory requests.
module seg_select
    import seg_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_req,
    input  logic [1:0]        acc_class,
    input  logic              ovr_valid,
    input  logic [IDX_W-1:0]  ovr_seg,
    output logic [IDX_W-1:0]  seg_idx
);

    acc_class_e cls;
    seg_idx_e   implied;
    logic       may_override;

    assign cls = acc_class_e'(acc_class);

    // Decode the implied segment and whether an override may replace it.
    always_comb begin
        may_override = 1'b0;
        case (cls)
            ACC_FETCH:  implied = SEG_CODE;
            ACC_DATA: begin
                implied      = SEG_DATA;
                may_override = 1'b1;
            end
            ACC_STACK: begin
                implied      = SEG_STACK;
                may_override = 1'b1;
            end
            default:    implied = SEG_EXTRA;
        endcase
    end

    // Pick the override when it is present and allowed.
    always_comb begin
        if (ovr_valid && may_override)
            seg_idx = ovr_seg;
        else
            seg_idx = implied;
    end

    // R3
    fetch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && acc_class == 2'd0) |-> (seg_idx == 2'd0));

    // R6
    strdst_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && acc_class == 2'd3) |-> (seg_idx == 2'd3));

    // R7
    override_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && ovr_valid && (acc_class == 2'd1 || acc_class == 2'd2)) |-> (seg_idx == ovr_seg));

endmodule

// File: rtl/seg_adder.sv
// Shift-and-add translator: phys = (seg << SHIFT) + offset, truncated to
// PHYS_W bits so that the carry out of the top bit is lost.
// Assumes PHYS_W >= SEG_W + SHIFT is not required; the sum is truncated.
module seg_adder #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int PHYS_W = 20
) (
    input  logic [SEG_W-1:0]  seg_base,
    input  logic [OFF_W-1:0]  offset,
    output logic [PHYS_W-1:0] phys
);

    localparam int SUM_W = PHYS_W + 1;

    logic [SUM_W-1:0] base_ext;
    logic [SUM_W-1:0] off_ext;
    logic [SUM_W-1:0] sum;

    // Widen both operands, add, and keep only PHYS_W bits.
    always_comb begin
        base_ext = SUM_W'({seg_base, {SHIFT{1'b0}}});
        off_ext  = SUM_W'(offset);
        sum      = base_ext + off_ext;
        phys     = sum[PHYS_W-1:0];
    end

    // R1
    always_comb begin
        low_bits_chk: assert (phys[SHIFT-1:0] == offset[SHIFT-1:0]);
    end

endmodule

// File: rtl/io_port_form.sv
// I/O port address former: zero-extends a NARROW_W-bit immediate port or
// passes a full IO_W-bit register port through.
// Assumes NARROW_W < IO_W.
module io_port_form #(
    parameter int IO_W     = 16,
    parameter int NARROW_W = 8
) (
    input  logic            wide,
    input  logic [IO_W-1:0] port_in,
    output logic [IO_W-1:0] port_out
);

    // Select full width or zero-extended low part.
    always_comb begin
        if (wide)
            port_out = port_in;
        else
            port_out = {{(IO_W-NARROW_W){1'b0}}, port_in[NARROW_W-1:0]};
    end

endmodule

// File: rtl/seg_addr_gen.sv
// Segmented physical address generator top: segment register file, segment
// choice, shift-add translation and I/O port forming, with a registered,
// valid-qualified result one cycle after each request.
// Assumes synchronous active-low reset and PHYS_W >= IO_W.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W    = 16,
    parameter int OFF_W    = 16,
    parameter int SHIFT    = 4,
    parameter int IO_W     = 16,
    parameter int NARROW_W = 8,
    parameter logic [SEG_W-1:0] CODE_RST = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_idx,
    input  logic [SEG_W-1:0]   wr_data,
    input  logic               req_valid,
    input  logic               req_io,
    input  logic               io_wide,
    input  logic [1:0]         acc_class,
    input  logic               ovr_valid,
    input  logic [1:0]         ovr_seg,
    input  logic [OFF_W-1:0]   offset,
    output logic               addr_valid,
    output logic               addr_is_io,
    output logic [SEG_W+SHIFT-1:0] addr
);

    localparam int PHYS_W = SEG_W + SHIFT;

    logic [IDX_W-1:0]  seg_idx;
    logic [SEG_W-1:0]  seg_base;
    logic [PHYS_W-1:0] phys;
    logic [IO_W-1:0]   port_addr;
    logic [PHYS_W-1:0] next_addr;
    logic              mem_req;

    assign mem_req = req_valid && !req_io;

    seg_regfile #(.SEG_W(SEG_W), .CODE_RST(CODE_RST)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (seg_idx),
        .rd_data (seg_base)
    );

    seg_select u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_req   (mem_req),
        .acc_class (acc_class),
        .ovr_valid (ovr_valid),
        .ovr_seg   (ovr_seg),
        .seg_idx   (seg_idx)
    );

    seg_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PHYS_W(PHYS_W)) u_add (
        .seg_base (seg_base),
        .offset   (offset),
        .phys     (phys)
    );

    io_port_form #(.IO_W(IO_W), .NARROW_W(NARROW_W)) u_io (
        .wide     (io_wide),
        .port_in  (IO_W'(offset)),
        .port_out (port_addr)
    );

    // Choose between the translated memory address and the I/O port address.
    always_comb begin
        if (req_io)
            next_addr = PHYS_W'(port_addr);
        else
            next_addr = phys;
    end

    // Register the result and its qualifiers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            addr_is_io <= 1'b0;
            addr       <= '0;
        end else begin
            addr_valid <= req_valid;
            if (req_valid) begin
                addr_is_io <= req_io;
                addr       <= next_addr;
            end
        end
    end

    // R12
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (addr_valid == $past(req_valid)));

    // R10
    io_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_is_io) |-> (addr[PHYS_W-1:IO_W] == '0));

    // R9
    io_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_io && !io_wide) |=> (addr[PHYS_W-1:NARROW_W] == '0));

endmodule

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_idx;
    logic [15:0] wr_data;
    logic        req_valid, req_io, io_wide, ovr_valid;
    logic [1:0]  acc_class, ovr_seg;
    logic [15:0] offset;
    logic        addr_valid, addr_is_io;
    logic [19:0] addr;

    int total = 0;
    int bad   = 0;
    logic [15:0] model [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .req_valid(req_valid), .req_io(req_io), .io_wide(io_wide), .acc_class(acc_class),
        .ovr_valid(ovr_valid), .ovr_seg(ovr_seg), .offset(offset),
        .addr_valid(addr_valid), .addr_is_io(addr_is_io), .addr(addr)
    );

    function automatic logic [1:0] exp_seg(input logic [1:0] cls, input logic ov, input logic [1:0] os);
        if (cls == 2'd0) return 2'd0;
        if (cls == 2'd3) return 2'd3;
        if (ov) return os;
        return cls;
    endfunction

    function automatic logic [19:0] exp_addr(input logic io, input logic wide, input logic [15:0] segv,
                                             input logic [15:0] off);
        if (io) return wide ? {4'h0, off} : {12'h0, off[7:0]};
        return ({segv, 4'h0} + {4'h0, off}) & 20'hFFFFF;
    endfunction

    task automatic check(input string tag, input logic ev, input logic eio, input logic [19:0] ea);
        total++;
        if (addr_valid !== ev || (ev && (addr_is_io !== eio || addr !== ea))) begin
            bad++;
            $display("FAIL %s: got valid=%0b io=%0b addr=%05h, expected valid=%0b io=%0b addr=%05h",
                     tag, addr_valid, addr_is_io, addr, ev, eio, ea);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_idx = 0; wr_data = 0; req_valid = 0; req_io = 0; io_wide = 0;
        acc_class = 0; ovr_valid = 0; ovr_seg = 0; offset = 0;
    endtask

    // Drive one cycle at a negedge, then check at the following negedge.
    task automatic cycle(input string tag, input logic rq, input logic io, input logic wide,
                         input logic [1:0] cls, input logic ov, input logic [1:0] os,
                         input logic [15:0] off, input logic we, input logic [1:0] wi,
                         input logic [15:0] wd);
        logic [15:0] segv;
        logic [19:0] ea;
        req_valid = rq; req_io = io; io_wide = wide; acc_class = cls;
        ovr_valid = ov; ovr_seg = os; offset = off; wr_en = we; wr_idx = wi; wr_data = wd;
        if (we) model[wi] = wd;
        segv = model[exp_seg(cls, ov, os)];
        ea = exp_addr(io, wide, segv, off);
        @(negedge clk);
        check(tag, rq, io, ea);
        idle_inputs();
    endtask

    initial begin
        int seed = 32'h5EA1;
        void'($urandom(seed));
        idle_inputs();
        rst_n = 0;
        model[0] = 16'hFFFF; model[1] = 0; model[2] = 0; model[3] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2: reset state
        check("R2 valid low after reset", 0, 0, 0);
        cycle("R2 code resets to FFFF", 1, 0, 0, 2'd0, 0, 0, 16'h0000, 0, 0, 0);
        cycle("R2 data resets to 0", 1, 0, 0, 2'd1, 0, 0, 16'h1234, 0, 0, 0);
        // R11: wrap
        cycle("R11 wrap FFFF:FFFF", 1, 0, 0, 2'd0, 0, 0, 16'hFFFF, 0, 0, 0);
        // R8: writes and same-cycle bypass
        cycle("R8 write data seg", 0, 0, 0, 0, 0, 0, 0, 1, 2'd1, 16'h1200);
        cycle("R4 data uses DS", 1, 0, 0, 2'd1, 0, 0, 16'h0034, 0, 0, 0);
        cycle("R8 bypass stack write", 1, 0, 0, 2'd2, 0, 0, 16'h0010, 1, 2'd2, 16'h3000);
        cycle("R5 stack uses SS", 1, 0, 0, 2'd2, 0, 0, 16'hFFFE, 0, 0, 0);
        cycle("R8 write extra", 0, 0, 0, 0, 0, 0, 0, 1, 2'd3, 16'hA000);
        cycle("R6 strdst uses ES", 1, 0, 0, 2'd3, 0, 0, 16'h0100, 0, 0, 0);
        cycle("R6 strdst ignores override", 1, 0, 0, 2'd3, 1, 2'd1, 16'h0100, 0, 0, 0);
        cycle("R3 fetch ignores override", 1, 0, 0, 2'd0, 1, 2'd2, 16'h0020, 0, 0, 0);
        for (int s = 0; s < 4; s++) begin
            cycle("R7 override on data", 1, 0, 0, 2'd1, 1, 2'(s), 16'h0F0F, 0, 0, 0);
            cycle("R7 override on stack", 1, 0, 0, 2'd2, 1, 2'(s), 16'h8001, 0, 0, 0);
        end
        cycle("R9 narrow port", 1, 1, 0, 2'd2, 0, 0, 16'hABCD, 0, 0, 0);
        cycle("R10 wide port", 1, 1, 1, 2'd0, 0, 0, 16'hABCD, 0, 0, 0);
        cycle("R12 idle", 0, 0, 0, 0, 0, 0, 16'h5555, 0, 0, 0);
        cycle("R1 write code then fetch", 1, 0, 0, 2'd0, 0, 0, 16'h0004, 1, 2'd0, 16'h1000);
        // Random mix covering R1 R3-R10 R11 R12
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r = $urandom();
            logic [31:0] q = $urandom();
            cycle("R1 random", r[0] | r[1], r[2] & r[3], r[4], r[6:5], r[7], r[9:8],
                  q[15:0], r[10] & r[11], r[13:12], (r[14] ? 16'hFFFF : q[31:16]));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule